// File: doc/BRIEF.md
# Handshaked Two-Wire Message Receiver

This block is the receiving end of a slow, fully handshaked serial link that uses two open-drain lines, Attention and Data, both with pull-ups. The sender places a bit on Data and then pulls Attention low. The receiver samples Data and acknowledges by holding Attention low itself. The sender then inverts Data. When the receiver sees Data move away from the sampled value, it releases Attention and waits for the line to float high before it will take the next bit. Nine bits make one message. The first bit is a flag that marks the message as a command (1) or as data (0), and the eight bits after it form a byte, sent most significant bit first.

The block never drives a line high. It outputs only a pull enable for Attention and watches the wired-AND levels of both lines through two-flop synchronisers. A low on Attention counts as a bit offer only after it has stayed low for a configurable number of cycles. A timer bounds every stage of a bit and the gap between bits. When the timer expires, the block releases Attention, drops the partial message, pulses an error flag and waits for Attention to return high. A momentary short of Attention to ground therefore cannot lock the link up.

The controller is a four-state machine. ST_IDLE waits for an accepted offer and leaves for ST_ACK, or for ST_RECOVER when a started message stalls. ST_ACK pulls Attention and waits for Data to reverse, leaving for ST_RELEASE, or for ST_RECOVER on timeout. ST_RELEASE waits for Attention to read high, leaving for ST_IDLE, or for ST_RECOVER on timeout. ST_RECOVER waits for Attention high and then returns to ST_IDLE.

Top module: `hsk2w_rx`

## Requirements
- R1: While reset is held and just after it is released, att_pull_o, msg_valid_o and msg_err_o are 0.
- R2: A low on att_line_i lasting fewer than LOW_CYCLES consecutive clocks causes no acknowledgement: att_pull_o stays 0. A low lasting long enough is acknowledged.
- R3: Once a bit is accepted, att_pull_o stays 1 for as long as dat_line_i keeps the sampled value, even while the sender stops pulling Attention.
- R4: After dat_line_i reverses from the sampled value, att_pull_o returns to 0 within a few clocks (two synchroniser stages plus one).
- R5: After releasing Attention, the block does not acknowledge again until att_line_i has read high. If the sender keeps Attention low, att_pull_o stays 0.
- R6: Nine accepted bits form a message. Bit 1 goes to msg_ctrl_o (1 = command, 0 = data) and bits 2 to 9 go to msg_byte_o, most significant bit first. msg_valid_o is a one-clock pulse after the ninth bit's Data reversal, with msg_ctrl_o and msg_byte_o valid in that clock.
- R7: If ST_ACK or ST_RELEASE lasts TIMEOUT_CYCLES clocks, or a started message waits that long for its next bit, the block releases att_pull_o and pulses msg_err_o for one clock. No msg_valid_o is produced for that message.
- R8: After a timeout, a line held low produces no further acknowledgement and no further error until att_line_i has read high.
- R9: Bits received before a timeout do not appear in any later message. The next nine bits form a complete new message.
- R10: msg_valid_o and msg_err_o are never 1 in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| att_line_i | input | 1 | Wired-AND level of the Attention line |
| dat_line_i | input | 1 | Level of the Data line |
| att_pull_o | output | 1 | 1 = pull Attention low (open-drain enable) |
| msg_valid_o | output | 1 | One-clock message-complete pulse |
| msg_ctrl_o | output | 1 | Flag bit of the message (1 = command) |
| msg_byte_o | output | DATA_W | Byte of the message |
| msg_err_o | output | 1 | One-clock timeout pulse |

## Verification
A stuck or skipped state shows at the Attention pull within one handshake. An acknowledgement that never comes, or a release that is missing after Data reverses, stalls the bench's sender within tens of clocks. A bit counter that is off by one or a wrong shift direction shows at the first msg_valid_o pulse, either as a wrong byte or flag or as a pulse that never arrives. A timer or recovery fault shows within one timeout window, as a missing or repeated msg_err_o pulse or as a renewed pull on a grounded line.

// File: rtl/hsk2w_rx_pkg.sv
package hsk2w_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK     = 2'd1,
        ST_RELEASE = 2'd2,
        ST_RECOVER = 2'd3
    } rx_state_t;

endpackage

// File: rtl/hsk2w_rx_sync.sv
module hsk2w_rx_sync #(
    parameter int SYNC_DEPTH = 2,
    parameter int LOW_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic att_raw,
    input  logic dat_raw,
    output logic att_s,
    output logic dat_s,
    output logic att_low_ok
);
    localparam int NLINES = 2;
    localparam int CW     = $clog2(LOW_CYCLES + 1);
    localparam logic [CW-1:0] CMAX = CW'(LOW_CYCLES - 1);

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [CW-1:0]     low_cnt;

    assign raw = {dat_raw, att_raw};

    // both lines idle high through their pull-ups, so reset the chains to 1
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_DEPTH-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_DEPTH-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_DEPTH-1];
    end

    assign att_s = synced[0];
    assign dat_s = synced[1];

    // count consecutive low cycles of Attention, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_cnt <= '0;
        else if (att_s)          low_cnt <= '0;
        else if (low_cnt < CMAX) low_cnt <= low_cnt + 1'b1;
    end

    assign att_low_ok = !att_s && (low_cnt == CMAX);

    if (LOW_CYCLES > 1) begin : g_chk
        // R2: an accepted low has already been low in the previous cycle
        a_r2_filter_span: assert property (@(posedge clk) disable iff (!rst_n)
            att_low_ok |-> $past(!att_s));
    end

endmodule

// File: rtl/hsk2w_rx_timer.sv
module hsk2w_rx_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] TMAX = TW'(LIMIT - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (restart || !run) cnt <= '0;
        else if (cnt != TMAX)     cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == TMAX);

    // R7: a stopped timer cannot report expiry in the next cycle
    a_r7_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && LIMIT > 1) |=> (cnt == '0));

endmodule

// File: rtl/hsk2w_rx_shift.sv
module hsk2w_rx_shift #(
    parameter int MSG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [MSG_W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (clr)      word <= '0;
        else if (shift_en) word <= {word[MSG_W-2:0], bit_in};
    end

    // R6: the newest bit enters at the low end, so the first bit ends up on top
    a_r6_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (word[0] == $past(bit_in)));

endmodule

// File: rtl/hsk2w_rx_fsm.sv
module hsk2w_rx_fsm
    import hsk2w_rx_pkg::*;
#(
    parameter int MSG_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic att_s,
    input  logic dat_s,
    input  logic att_low_ok,
    input  logic expired,
    output logic att_pull,
    output logic shift_en,
    output logic shift_clr,
    output logic timer_run,
    output logic timer_restart,
    output logic msg_valid,
    output logic msg_err
);
    localparam int IW = $clog2(MSG_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(MSG_W - 1);

    rx_state_t     state_q, state_d;
    logic          held_q;
    logic [IW-1:0] idx_q;
    logic          take, rev, go_rec;

    // next state
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        rev     = 1'b0;
        go_rec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (expired) begin
                    go_rec  = 1'b1;
                    state_d = ST_RECOVER;
                end else if (att_low_ok) begin
                    take    = 1'b1;
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                if (dat_s != held_q) begin
                    rev     = 1'b1;
                    state_d = ST_RELEASE;
                end else if (expired) begin
                    go_rec  = 1'b1;
                    state_d = ST_RECOVER;
                end
            end
            ST_RELEASE: begin
                if (att_s) begin
                    state_d = ST_IDLE;
                end else if (expired) begin
                    go_rec  = 1'b1;
                    state_d = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (att_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and message bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q    <= 1'b0;
            idx_q     <= '0;
            msg_valid <= 1'b0;
            msg_err   <= 1'b0;
        end else begin
            msg_valid <= rev && (idx_q == LAST_IDX);
            msg_err   <= go_rec;
            if (take) held_q <= dat_s;
            if (go_rec)
                idx_q <= '0;
            else if (rev)
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    assign att_pull      = (state_q == ST_ACK);
    assign shift_en      = take;
    assign shift_clr     = go_rec;
    assign timer_run     = (state_q == ST_ACK) || (state_q == ST_RELEASE) ||
                           ((state_q == ST_IDLE) && (idx_q != '0));
    assign timer_restart = (state_d != state_q);

    // R6: message pulse lasts one clock
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);
    // R7: error pulse lasts one clock and comes with Attention released
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        msg_err |=> !msg_err);
    a_r7_err_released: assert property (@(posedge clk) disable iff (!rst_n)
        msg_err |-> !att_pull);
    // R10: completion and error never coincide
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_valid && msg_err));
    // R5: after a release there is at least one clock before any new pull
    a_r5_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(att_pull) |=> !att_pull);
    // R3: the pull holds while Data keeps the sampled value and time remains
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (att_pull && (dat_s == held_q) && !expired) |=> att_pull);
    // R8: no acknowledgement while recovering from a line still held low
    a_r8_no_reack: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RECOVER) && !att_s) |=> !att_pull);

endmodule

// File: rtl/hsk2w_rx.sv
module hsk2w_rx #(
    parameter int DATA_W         = 8,
    parameter int SYNC_DEPTH     = 2,
    parameter int LOW_CYCLES     = 4,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              att_line_i,
    input  logic              dat_line_i,
    output logic              att_pull_o,
    output logic              msg_valid_o,
    output logic              msg_ctrl_o,
    output logic [DATA_W-1:0] msg_byte_o,
    output logic              msg_err_o
);
    localparam int MSG_W = DATA_W + 1;

    logic             att_s, dat_s, att_low_ok;
    logic             expired, timer_run, timer_restart;
    logic             shift_en, shift_clr;
    logic [MSG_W-1:0] word;

    hsk2w_rx_sync #(
        .SYNC_DEPTH (SYNC_DEPTH),
        .LOW_CYCLES (LOW_CYCLES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .att_raw    (att_line_i),
        .dat_raw    (dat_line_i),
        .att_s      (att_s),
        .dat_s      (dat_s),
        .att_low_ok (att_low_ok)
    );

    hsk2w_rx_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .restart (timer_restart),
        .expired (expired)
    );

    hsk2w_rx_shift #(
        .MSG_W (MSG_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (shift_clr),
        .shift_en (shift_en),
        .bit_in   (dat_s),
        .word     (word)
    );

    hsk2w_rx_fsm #(
        .MSG_W (MSG_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .att_s         (att_s),
        .dat_s         (dat_s),
        .att_low_ok    (att_low_ok),
        .expired       (expired),
        .att_pull      (att_pull_o),
        .shift_en      (shift_en),
        .shift_clr     (shift_clr),
        .timer_run     (timer_run),
        .timer_restart (timer_restart),
        .msg_valid     (msg_valid_o),
        .msg_err       (msg_err_o)
    );

    assign msg_ctrl_o = word[MSG_W-1];
    assign msg_byte_o = word[DATA_W-1:0];

endmodule

// File: tb/hsk2w_rx_tb.sv
module hsk2w_rx_tb;

    localparam int DATA_W = 8;
    localparam int LOWC   = 4;
    localparam int TMO    = 200;
    localparam int NVEC   = 6;
    localparam int WDOG   = 150000;
    // {flag, byte}: flag 1 = command
    localparam logic [8:0] VEC [NVEC] = '{9'h1A5, 9'h03C, 9'h100, 9'h0FF, 9'h181, 9'h05A};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic att_drv = 1'b0;
    logic dat_drv = 1'b1;
    logic att_pull, msg_valid, msg_ctrl, msg_err;
    logic [DATA_W-1:0] msg_byte;
    logic att_line, dat_line;

    int n_chk = 0, n_bad = 0;
    int vcnt = 0, ecnt = 0, rises = 0, both = 0, cyc = 0;
    logic [8:0] cap = '0;
    logic prev_pull = 1'b0;
    bit hold_bad = 0, linger_bad = 0;

    assign att_line = ~(att_drv | att_pull);
    assign dat_line = dat_drv;

    always #10 clk = ~clk;

    hsk2w_rx #(
        .DATA_W (DATA_W), .SYNC_DEPTH (2),
        .LOW_CYCLES (LOWC), .TIMEOUT_CYCLES (TMO)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .att_line_i (att_line), .dat_line_i (dat_line),
        .att_pull_o (att_pull), .msg_valid_o (msg_valid),
        .msg_ctrl_o (msg_ctrl), .msg_byte_o (msg_byte),
        .msg_err_o (msg_err)
    );

    // monitor, sampled on the falling edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (msg_valid) begin vcnt <= vcnt + 1; cap <= {msg_ctrl, msg_byte}; end
            if (msg_err)   ecnt <= ecnt + 1;
            if (msg_valid && msg_err) both <= both + 1;
            if (att_pull && !prev_pull) rises <= rises + 1;
            prev_pull <= att_pull;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit linger, output bit ok);
        bit acked = 0;
        ok = 1;
        dat_drv = b;
        repeat (3) @(negedge clk);
        for (int t = 0; t < 20 && !acked; t++) begin
            att_drv = 1'b1;
            repeat (8) @(negedge clk);
            att_drv = 1'b0;
            repeat (3) @(negedge clk);
            acked = att_pull;
        end
        if (!acked) begin ok = 0; return; end
        // sender no longer pulls; the receiver must keep holding
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            if (!att_pull) hold_bad = 1;
        end
        if (linger) att_drv = 1'b1;
        dat_drv = ~b;
        for (int t = 0; t < 30 && att_pull; t++) @(negedge clk);
        if (att_pull) begin ok = 0; return; end
        if (linger) begin
            for (int t = 0; t < 12; t++) begin
                @(negedge clk);
                if (att_pull) linger_bad = 1;
            end
            att_drv = 1'b0;
        end
        for (int t = 0; t < 10 && !att_line; t++) @(negedge clk);
        dat_drv = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_msg(input logic [8:0] m, input int linger_at, output bit ok);
        bit okb;
        ok = 1;
        for (int i = 8; i >= 0; i--) begin
            send_bit(m[i], (i == linger_at), okb);
            if (!okb) ok = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic msg_and_check(input logic [8:0] m, input int linger_at, input string req);
        int v0 = vcnt;
        int e0 = ecnt;
        bit ok;
        send_msg(m, linger_at, ok);
        check(ok, {req, "/R4 handshake completes"}, int'(ok), 1);
        check(vcnt == v0 + 1, {req, "/R6 one valid pulse"}, vcnt - v0, 1);
        check(cap == m, {req, "/R6 flag and byte"}, int'(cap), int'(m));
        check(ecnt == e0, {req, "/R7 no error"}, ecnt - e0, 0);
    endtask

    initial begin : watchdog
        wait (cyc >= WDOG);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int r0, e0, v0;
        bit ok;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!att_pull && !msg_valid && !msg_err, "R1 outputs in reset",
              {att_pull, msg_valid, msg_err}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!att_pull && !msg_valid && !msg_err, "R1 outputs after reset",
              {att_pull, msg_valid, msg_err}, 0);

        // R2: a short low is filtered out
        r0 = rises;
        att_drv = 1'b1;
        repeat (LOWC - 1) @(negedge clk);
        att_drv = 1'b0;
        repeat (20) @(negedge clk);
        check(rises == r0, "R2 short low ignored", rises - r0, 0);

        // R6: table of messages
        for (int k = 0; k < NVEC; k++) msg_and_check(VEC[k], -1, "R6 vec");
        check(!hold_bad, "R3 pull held during sender release", int'(hold_bad), 0);

        // R5: sender keeps Attention low across the release
        msg_and_check(9'h0C3, 4, "R5 linger");
        check(!linger_bad, "R5 no re-ack while line low", int'(linger_bad), 0);

        // R7/R9: stall between bits, partial message dropped
        e0 = ecnt; v0 = vcnt;
        for (int i = 8; i >= 5; i--) begin
            send_bit(1'b1, 0, ok);
        end
        repeat (TMO + 100) @(negedge clk);
        check(ecnt == e0 + 1, "R7 stall error pulse", ecnt - e0, 1);
        check(vcnt == v0, "R7 no valid for partial", vcnt - v0, 0);
        msg_and_check(9'h012, -1, "R9 after stall");

        // R7/R8: acknowledged bit never completed, line held low
        e0 = ecnt; r0 = rises;
        dat_drv = 1'b0;
        repeat (3) @(negedge clk);
        att_drv = 1'b1;
        repeat (3 * TMO) @(negedge clk);
        check(!att_pull, "R7 pull released on timeout", int'(att_pull), 0);
        check(ecnt == e0 + 1, "R8 single error on held line", ecnt - e0, 1);
        check(rises == r0 + 1, "R8 no re-ack on held line", rises - r0, 1);
        att_drv = 1'b0;
        dat_drv = 1'b1;
        repeat (10) @(negedge clk);
        msg_and_check(9'h1E7, -1, "R9 after ack timeout");

        check(both == 0, "R10 valid and error apart", both, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule